// File: doc/BRIEF.md
# I2C Slave Memory Read Engine

This block is the read side of a byte-addressed I2C slave memory. It watches the open-drain SCL and SDA lines through a fast system clock, recognises start and stop conditions, matches its 7-bit device address and serves three kinds of read. A current-address read returns the byte at the internal pointer. A random read first takes a byte address in a write-direction frame, then reads after a repeated start. Either read becomes a sequential read when the master keeps acknowledging.

The byte array sits beside the engine. The engine presents the pointer on a combinational read port and takes the addressed byte back in the same cycle. A single word-address counter serves every read mode. It steps once per transmitted byte across all address bits and wraps from the top location to zero, so a sequential read can run for any length. SDA is never driven high. The engine only asserts a pull-down enable, and an external resistor supplies the high level.

Top module: `i2c_rd_engine`

## Requirements
- R1: A start is SDA falling while SCL is high. A stop is SDA rising while SCL is high. A start in any state restarts device-address reception. After a stop the pull-down is released and the engine idles.
- R2: The device address is binary 1010 followed by strap_i[2:0], sent MSB first, with the eighth bit as direction (1 = read). On a match the engine pulls SDA low for the ninth (acknowledge) clock.
- R3: On an address mismatch the engine does not acknowledge. It leaves SDA released for all following bytes and leaves the pointer unchanged until the next start.
- R4: In a write-direction frame, the byte after the acknowledged device address is loaded into the pointer and acknowledged. A repeated start with a read-direction address then returns the byte at that address.
- R5: A read-direction frame returns the byte at the current pointer, MSB first, one bit per SCL clock.
- R6: Every transmitted data byte advances the full 8-bit pointer by one. Each master acknowledge (SDA low in the ninth clock) makes the engine send the next byte.
- R7: After location 255 is sent, the pointer wraps to 0 and data keeps flowing for each further acknowledge.
- R8: When the master does not acknowledge, the engine releases SDA and waits for a start or stop. The pointer keeps its advanced value for the next current-address read.
- R9: SDA is only pulled low or released, and the pull-down enable changes only while SCL is low.
- R10: After reset the pull-down is released and the pointer is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the SCL rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| strap_i | input | 3 | Low three device-address bits |
| sda_oe_o | output | 1 | 1 = pull SDA low, 0 = release |
| mem_addr_o | output | AW (8) | Word address to the byte array |
| mem_data_i | input | 8 | Byte read from the array at mem_addr_o |

## Verification
The bench goes after pointer wrap by running a sequential read across location 255. A counter that stepped only its low bits, or saturated, would return the wrong bytes after the top location. It reads again after a master not-acknowledge, which catches a design that rewinds the pointer or skips the increment on the final byte. A foreign-address frame that carries a byte address is followed by a current-address read, which exposes a design that acknowledges, or that loads the pointer, while it should be ignoring the bus. A watcher on SCL-high intervals flags any change of the pull-down that would look like a false start or stop to other devices on the bus.

// File: rtl/i2c_rd_pkg.sv
package i2c_rd_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEV,
    ST_DEV_ACK,
    ST_WADDR,
    ST_WADDR_ACK,
    ST_TX,
    ST_RX_ACK,
    ST_WAIT
  } rd_state_e;

  localparam logic [3:0] DEV_PREFIX = 4'b1010;
  localparam int unsigned BYTE_W = 8;

endpackage

// File: rtl/i2c_rd_sync.sv
module i2c_rd_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);

  logic [STAGES-1:0] scl_sr;
  logic [STAGES-1:0] sda_sr;
  logic              scl_d;
  logic              sda_d;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          scl_sr <= '1;
          sda_sr <= '1;
        end else begin
          scl_sr <= scl_i;
          sda_sr <= sda_i;
        end
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          scl_sr <= '1;
          sda_sr <= '1;
        end else begin
          scl_sr <= {scl_sr[STAGES-2:0], scl_i};
          sda_sr <= {sda_sr[STAGES-2:0], sda_i};
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_d <= scl_sr[STAGES-1];
      sda_d <= sda_sr[STAGES-1];
    end
  end

  assign scl_s     = scl_sr[STAGES-1];
  assign sda_s     = sda_sr[STAGES-1];
  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  assign start_det = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;

endmodule

// File: rtl/i2c_rd_ptr.sv
module i2c_rd_ptr #(
  parameter int unsigned AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] load_val,
  input  logic          inc,
  output logic [AW-1:0] ptr
);

  logic [AW-1:0] ptr_q;
  logic [AW-1:0] ptr_d;
  logic          ptr_en;

  always_comb begin
    ptr_en = load | inc;
    ptr_d  = ptr_q;
    if (load) begin
      ptr_d = load_val;
    end else if (inc) begin
      ptr_d = ptr_q + {{(AW-1){1'b0}}, 1'b1};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
    end else if (ptr_en) begin
      ptr_q <= ptr_d;
    end
  end

  assign ptr = ptr_q;

endmodule

// File: rtl/i2c_rd_fsm.sv
module i2c_rd_fsm
  import i2c_rd_pkg::*;
#(
  parameter int unsigned AW = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [2:0]              strap_i,
  input  logic                    sda_s,
  input  logic                    scl_rise,
  input  logic                    scl_fall,
  input  logic                    start_det,
  input  logic                    stop_det,
  input  logic [BYTE_W-1:0]       mem_data,
  output logic                    sda_oe,
  output logic                    ptr_load,
  output logic [AW-1:0]           ptr_val,
  output logic                    ptr_inc,
  output rd_state_e               state_o
);

  localparam int unsigned CNT_W = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

  rd_state_e          state_q, state_d;
  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic [BYTE_W-1:0]  sh_q, sh_d;
  logic               oe_q, oe_d;
  logic               mack_q, mack_d;
  logic               addr_hit;

  assign addr_hit = (sh_q[BYTE_W-1:1] == {DEV_PREFIX, strap_i});

  always_comb begin
    state_d  = state_q;
    cnt_d    = cnt_q;
    sh_d     = sh_q;
    oe_d     = oe_q;
    mack_d   = mack_q;
    ptr_load = 1'b0;
    ptr_inc  = 1'b0;
    if (stop_det) begin
      state_d = ST_IDLE;
      oe_d    = 1'b0;
    end else if (start_det) begin
      state_d = ST_DEV;
      cnt_d   = '0;
      oe_d    = 1'b0;
    end else begin
      case (state_q)
        ST_DEV, ST_WADDR: begin
          if (scl_rise && cnt_q != CNT_FULL) begin
            sh_d  = {sh_q[BYTE_W-2:0], sda_s};
            cnt_d = cnt_q + CNT_ONE;
          end else if (scl_fall && cnt_q == CNT_FULL) begin
            if (state_q == ST_WADDR) begin
              ptr_load = 1'b1;
              state_d  = ST_WADDR_ACK;
              oe_d     = 1'b1;
            end else if (addr_hit) begin
              state_d = ST_DEV_ACK;
              oe_d    = 1'b1;
            end else begin
              state_d = ST_WAIT;
            end
          end
        end
        ST_DEV_ACK: begin
          if (scl_fall) begin
            cnt_d = '0;
            if (sh_q[0]) begin
              state_d = ST_TX;
              sh_d    = mem_data;
              oe_d    = ~mem_data[BYTE_W-1];
            end else begin
              state_d = ST_WADDR;
              oe_d    = 1'b0;
            end
          end
        end
        ST_WADDR_ACK: begin
          if (scl_fall) begin
            state_d = ST_WAIT;
            oe_d    = 1'b0;
          end
        end
        ST_TX: begin
          if (scl_rise && cnt_q != CNT_FULL) begin
            cnt_d = cnt_q + CNT_ONE;
          end else if (scl_fall) begin
            if (cnt_q == CNT_FULL) begin
              state_d = ST_RX_ACK;
              oe_d    = 1'b0;
              ptr_inc = 1'b1;
            end else begin
              sh_d = {sh_q[BYTE_W-2:0], 1'b0};
              oe_d = ~sh_q[BYTE_W-2];
            end
          end
        end
        ST_RX_ACK: begin
          if (scl_rise) begin
            mack_d = ~sda_s;
          end else if (scl_fall) begin
            cnt_d = '0;
            if (mack_q) begin
              state_d = ST_TX;
              sh_d    = mem_data;
              oe_d    = ~mem_data[BYTE_W-1];
            end else begin
              state_d = ST_WAIT;
              oe_d    = 1'b0;
            end
          end
        end
        default: begin
          oe_d = 1'b0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      sh_q    <= '0;
      oe_q    <= 1'b0;
      mack_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      sh_q    <= sh_d;
      oe_q    <= oe_d;
      mack_q  <= mack_d;
    end
  end

  assign sda_oe  = oe_q;
  assign ptr_val = sh_q[AW-1:0];
  assign state_o = state_q;

endmodule

// File: rtl/i2c_rd_engine.sv
module i2c_rd_engine
  import i2c_rd_pkg::*;
#(
  parameter int unsigned AW          = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic [2:0]        strap_i,
  output logic              sda_oe_o,
  output logic [AW-1:0]     mem_addr_o,
  input  logic [BYTE_W-1:0] mem_data_i
);

  logic [1:0]    rst_sr;
  logic          rst_n_s;
  logic          scl_s;
  logic          sda_s;
  logic          scl_rise;
  logic          scl_fall;
  logic          start_det;
  logic          stop_det;
  logic          ptr_load;
  logic          ptr_inc;
  logic [AW-1:0] ptr_val;
  logic [AW-1:0] ptr;
  rd_state_e     state;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sr <= '0;
    end else begin
      rst_sr <= {rst_sr[0], 1'b1};
    end
  end
  assign rst_n_s = rst_sr[1];

  i2c_rd_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .scl_s     (scl_s),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  i2c_rd_fsm #(.AW(AW)) fsm_i (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .strap_i   (strap_i),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det),
    .mem_data  (mem_data_i),
    .sda_oe    (sda_oe_o),
    .ptr_load  (ptr_load),
    .ptr_val   (ptr_val),
    .ptr_inc   (ptr_inc),
    .state_o   (state)
  );

  i2c_rd_ptr #(.AW(AW)) ptr_i (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .load     (ptr_load),
    .load_val (ptr_val),
    .inc      (ptr_inc),
    .ptr      (ptr)
  );

  assign mem_addr_o = ptr;

endmodule

// File: rtl/i2c_rd_engine_chk.sv
module i2c_rd_engine_chk
  import i2c_rd_pkg::*;
#(
  parameter int unsigned AW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          scl_s,
  input logic          sda_oe,
  input logic          stop_det,
  input logic          ptr_inc,
  input logic          ptr_load,
  input logic [AW-1:0] ptr,
  input rd_state_e     state
);

  p_oe_scl_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl_s);

  p_stop_release_r1: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> (!sda_oe && state == ST_IDLE));

  p_wait_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_WAIT) |-> !sda_oe);

  p_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr_inc && !ptr_load) |=> ptr == AW'($past(ptr) + 1'b1));

  p_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr_inc && !ptr_load && ptr == '1) |=> ptr == '0);

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!ptr_inc && !ptr_load) |=> $stable(ptr));

endmodule

bind i2c_rd_engine i2c_rd_engine_chk #(.AW(AW)) chk_i (
  .clk      (clk),
  .rst_n    (rst_n_s),
  .scl_s    (scl_s),
  .sda_oe   (sda_oe_o),
  .stop_det (stop_det),
  .ptr_inc  (ptr_inc),
  .ptr_load (ptr_load),
  .ptr      (ptr),
  .state    (state)
);

// File: tb/i2c_rd_engine_tb_top.sv
module i2c_rd_engine_tb_top;

  localparam int Q = 40;
  localparam logic [6:0] DEV    = 7'b1010_101;
  localparam logic [6:0] BADDEV = 7'b1010_011;

  typedef struct {
    logic [7:0] data;
    string      req;
  } exp_t;

  logic       clk;
  logic       rst_n;
  logic       scl;
  logic       m_low;
  logic       dut_oe;
  logic [7:0] mem_addr;
  logic [7:0] mem_data;
  wire        sda_bus = ~(dut_oe | m_low);

  int         nchk;
  int         nerr;
  int         hi_changes;
  logic       prev_oe;
  logic [7:0] ptr_model;
  logic [7:0] got;
  exp_t       exp_q[$];
  event       byte_ev;

  function automatic logic [7:0] mem_f(input logic [7:0] a);
    return (a * 8'd29) ^ 8'h6B;
  endfunction

  assign mem_data = mem_f(mem_addr);

  i2c_rd_engine dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_i      (scl),
    .sda_i      (sda_bus),
    .strap_i    (3'b101),
    .sda_oe_o   (dut_oe),
    .mem_addr_o (mem_addr),
    .mem_data_i (mem_data)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] expv);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s: actual %0h expected %0h", req, act, expv);
    end
  endtask

  task automatic summary;
    $display("  Simulation finished: %0d checks, %0d errors", nchk, nerr);
  endtask

  // Watches for pull-down changes while SCL is high (R9)
  always @(negedge clk) begin
    if (rst_n && dut_oe !== prev_oe && scl) hi_changes++;
    prev_oe <= dut_oe;
  end

  // Scoreboard monitor
  initial begin
    forever begin
      @(byte_ev);
      if (exp_q.size() == 0) begin
        chk(1'b0, "scoreboard", {24'd0, got}, 32'd0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        chk(got == e.data, e.req, {24'd0, got}, {24'd0, e.data});
      end
    end
  end

  task automatic wq;
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start;
    m_low = 1'b0; wq; scl = 1'b1; wq; m_low = 1'b1; wq; scl = 1'b0; wq;
  endtask

  task automatic bus_stop;
    m_low = 1'b1; wq; scl = 1'b1; wq; m_low = 1'b0; wq;
  endtask

  task automatic put_bit(input logic b);
    m_low = ~b; wq; scl = 1'b1; wq; wq; scl = 1'b0; wq;
  endtask

  task automatic get_bit(output logic b);
    m_low = 1'b0; wq; scl = 1'b1; wq; b = sda_bus; wq; scl = 1'b0; wq;
  endtask

  task automatic put_byte(input logic [7:0] v, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) put_bit(v[i]);
    get_bit(b);
    ack = ~b;
  endtask

  task automatic get_byte(input logic mack);
    logic [7:0] v;
    logic b;
    v = '0;
    for (int i = 0; i < 8; i++) begin
      get_bit(b);
      v = {v[6:0], b};
    end
    put_bit(~mack);
    got = v;
    ->byte_ev;
  endtask

  // Driver: read n bytes from the current pointer, then stop
  task automatic cur_read(input int n, input string req);
    logic ack;
    bus_start;
    put_byte({DEV, 1'b1}, ack);
    chk(ack, "R2", {31'd0, ack}, 32'd1);
    for (int i = 0; i < n; i++) begin
      exp_q.push_back('{data: mem_f(ptr_model), req: req});
      ptr_model = ptr_model + 8'd1;
      get_byte(i != n - 1);
    end
    bus_stop;
  endtask

  task automatic rand_read(input logic [7:0] a, input int n, input string req);
    logic ack;
    bus_start;
    put_byte({DEV, 1'b0}, ack);
    chk(ack, "R2", {31'd0, ack}, 32'd1);
    put_byte(a, ack);
    chk(ack, "R4", {31'd0, ack}, 32'd1);
    ptr_model = a;
    cur_read(n, req);
  endtask

  initial begin
    logic ack;
    nchk = 0; nerr = 0; hi_changes = 0; ptr_model = 8'd0;
    scl = 1'b1; m_low = 1'b0; prev_oe = 1'b0;
    rst_n = 1'b0;
    repeat (10) @(negedge clk);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);

    chk(dut_oe == 1'b0, "R10", {31'd0, dut_oe}, 32'd0);
    cur_read(1, "R10");             // pointer starts at 0
    cur_read(1, "R8");              // advanced after NACK
    rand_read(8'h40, 1, "R4");
    cur_read(4, "R6");              // sequential 0x41..0x44
    rand_read(8'hFD, 5, "R7");      // FD FE FF 00 01
    chk(dut_oe == 1'b0, "R1", {31'd0, dut_oe}, 32'd0);

    // Foreign write frame with a byte address: ignored (R3)
    bus_start;
    put_byte({BADDEV, 1'b0}, ack);
    chk(!ack, "R3", {31'd0, ack}, 32'd0);
    put_byte(8'h10, ack);
    chk(!ack, "R3", {31'd0, ack}, 32'd0);
    bus_stop;
    cur_read(1, "R3");              // pointer untouched

    // Foreign read frame: bus stays released (R3)
    bus_start;
    put_byte({BADDEV, 1'b1}, ack);
    chk(!ack, "R3", {31'd0, ack}, 32'd0);
    exp_q.push_back('{data: 8'hFF, req: "R3"});
    get_byte(1'b0);
    bus_stop;

    // Repeated start restarts address reception (R1)
    bus_start;
    put_byte({BADDEV, 1'b1}, ack);
    chk(!ack, "R1", {31'd0, ack}, 32'd0);
    cur_read(2, "R5");
    chk(dut_oe == 1'b0, "R1", {31'd0, dut_oe}, 32'd0);

    chk(exp_q.size() == 0, "R6", exp_q.size(), 32'd0);
    chk(hi_changes == 0, "R9", hi_changes, 32'd0);
    summary;
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    nchk++;
    nerr++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary;
    $finish;
  end

endmodule